// File: doc/BRIEF.md
# Serial Flash Deep Power-Down and Signature Responder

This block sits on the serial-peripheral slave side of a flash device and deals with two commands only. The first puts the part into a deep power-down state. The second releases the part from that state and reads back an 8-bit device signature. Serial clock, select and data-in come from the pins. They are synchronised into the system clock domain and edge-detected. Data-in is captured on rising serial-clock edges, and the signature is driven on falling edges.

The first byte after select falls is the opcode. A deep power-down opcode (0xB9) takes effect only if select rises exactly on the byte boundary that ends it. A release opcode (0xAB) is followed by three dummy bytes, and then the signature 0x12 is shifted out MSB first. The signature repeats for as long as the clock keeps running. While the part is powered down, every opcode except release is ignored. After a release from power-down, the part spends a parameterised number of system clocks in a wake-up state before it reports standby again. If select falls during that delay, an error pulse is raised. While an erase, program or status write is in progress (`busy`), neither opcode is decoded.

Top module: `spi_pd_responder`

## Requirements
- R1: After reset, `standby` is 1, and `deepPd`, `soOe` and `wakeErr` are 0.
- R2: From standby, 0xB9 followed by select rising after exactly 8 clocks sets `deepPd` and clears `standby`. The same opcode with more clocks before select rises changes nothing.
- R3: While powered down, any opcode other than 0xAB leaves `deepPd` at 1 and never raises `soOe`.
- R4: After 0xAB and three dummy bytes (clocks 0 to 31), `soData` presents 0x12 MSB first from clock 32 onward. It updates on falling edges, and `soOe` is 1 during that phase.
- R5: If clocks continue after the 8 signature bits, the signature is sent again from its MSB with no gap.
- R6: When `busy` is 1 as the opcode completes, 0xAB and 0xB9 are not decoded: `soOe` stays 0 and the power state does not change.
- R7: 0xAB issued in standby returns the signature and leaves `standby` at 1, with no wake-up delay.
- R8: 0xAB issued while powered down makes `standby` and `deepPd` both 0 once select rises. They stay 0 for WAKE_CYC system clocks, after which `standby` returns to 1.
- R9: A falling select during the wake-up delay produces a one-clock `wakeErr` pulse. The delay still completes.
- R10: `soOe` is 0 whenever select is high and before the signature phase begins.
- R11: An opcode cut short (select rises before 8 clocks) is discarded with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock pin |
| csNIn | input | 1 | Active-low select pin |
| siIn | input | 1 | Serial data in |
| busy | input | 1 | Erase, program or status write in progress |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Output enable for serial data out |
| standby | output | 1 | Part is in standby |
| deepPd | output | 1 | Part is in deep power-down |
| wakeErr | output | 1 | One-clock pulse when select falls during wake-up |

## Verification
The hardest situation to reach is select falling inside the wake-up window. Reaching it takes a complete power-down entry, then a full release opcode, and then a select pulse timed within WAKE_CYC clocks of the release. The bench builds that sequence directly and checks the pulse count and the later return to standby. The boundary condition on power-down entry is exercised by random transaction lengths. Some transactions end exactly on 8 clocks, some are cut short, and some run on into the signature phase, so entry is seen both taken and refused, with and without `busy`.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;
  localparam logic [7:0] OP_RELEASE = 8'hAB;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'd0,
    PWR_DEEP    = 2'd1,
    PWR_WAKE    = 2'd2
  } pwr_state_t;

  // control -> datapath
  typedef struct packed {
    logic sigArm;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic       opValid;
    logic [7:0] opcode;
    logic       csRise;
    logic       csFall;
    logic       atOpEnd;
  } dp_event_t;
endpackage

// File: rtl/spi_pd_datapath.sv
module spi_pd_datapath
  import spi_pd_pkg::*;
#(
  parameter int SIG_W       = 8,
  parameter logic [SIG_W-1:0] SIG_VAL = 8'h12,
  parameter int DUMMY_BYTES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sckIn,
  input  logic         csNIn,
  input  logic         siIn,
  input  ctrl_strobe_t strobe,
  output dp_event_t    ev,
  output logic         soData,
  output logic         soOe,
  output logic         csHigh
);
  localparam int BYTE_W = $clog2(DUMMY_BYTES + 2);
  localparam int SIDX_W = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam logic [BYTE_W-1:0] OUT_BYTE = BYTE_W'(DUMMY_BYTES + 1);
  localparam logic [2:0] RST_VAL = 3'b010;

  logic [2:0] rawIn;
  logic [2:0] syncd;
  assign rawIn = {siIn, csNIn, sckIn};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {SYNC_STAGES{RST_VAL[g]}};
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncd[g] = pipe[SYNC_STAGES-1];
  end

  logic sckS, csS, siS;
  assign sckS = syncd[0];
  assign csS  = syncd[1];
  assign siS  = syncd[2];

  logic sckPrev, csPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  logic sckRise, sckFall;
  assign sckRise = sckS & ~sckPrev & ~csS;
  assign sckFall = ~sckS & sckPrev & ~csS;

  // bit and byte framing
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteCnt;
  logic [6:0]        rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      rxShift <= '0;
    end else if (csS) begin
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (sckRise) begin
      rxShift <= {rxShift[5:0], siS};
      bitCnt  <= bitCnt + 3'd1;
      if (bitCnt == 3'd7 && byteCnt != OUT_BYTE)
        byteCnt <= byteCnt + 1'b1;
    end
  end

  assign ev.opValid = sckRise && (bitCnt == 3'd7) && (byteCnt == '0);
  assign ev.opcode  = {rxShift, siS};
  assign ev.csRise  = csS & ~csPrev;
  assign ev.csFall  = ~csS & csPrev;
  assign ev.atOpEnd = (byteCnt == BYTE_W'(1)) && (bitCnt == 3'd0);
  assign csHigh     = csS;

  // signature shifter
  logic              sigArmed;
  logic [SIDX_W-1:0] sigIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigArmed <= 1'b0;
      sigIdx   <= '0;
      soData   <= 1'b0;
      soOe     <= 1'b0;
    end else if (csS) begin
      sigArmed <= 1'b0;
      sigIdx   <= '0;
      soOe     <= 1'b0;
    end else begin
      if (strobe.sigArm) sigArmed <= 1'b1;
      if (sckFall && sigArmed && byteCnt == OUT_BYTE) begin
        soData <= SIG_VAL[SIG_W-1-int'(sigIdx)];
        soOe   <= 1'b1;
        if (sigIdx == SIDX_W'(SIG_W - 1)) sigIdx <= '0;
        else                              sigIdx <= sigIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_pd_ctrl.sv
module spi_pd_ctrl
  import spi_pd_pkg::*;
#(
  parameter int WAKE_CYC = 200
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busy,
  input  dp_event_t    ev,
  output ctrl_strobe_t strobe,
  output logic         standby,
  output logic         deepPd,
  output logic         wakeErr
);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  pwr_state_t  pwrState;
  logic        pendRel, pendSleep;
  logic [WAKE_W-1:0] wakeCnt;

  logic decodeOk;
  assign decodeOk = ev.opValid && !busy && (pwrState != PWR_WAKE);

  assign strobe.sigArm = decodeOk && (ev.opcode == OP_RELEASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState  <= PWR_STANDBY;
      pendRel   <= 1'b0;
      pendSleep <= 1'b0;
      wakeCnt   <= '0;
      wakeErr   <= 1'b0;
    end else begin
      wakeErr <= ev.csFall && (pwrState == PWR_WAKE);
      if (decodeOk) begin
        if (ev.opcode == OP_RELEASE)
          pendRel <= 1'b1;
        else if (ev.opcode == OP_SLEEP && pwrState == PWR_STANDBY)
          pendSleep <= 1'b1;
      end
      if (ev.csRise) begin
        pendRel   <= 1'b0;
        pendSleep <= 1'b0;
      end
      case (pwrState)
        PWR_STANDBY:
          if (ev.csRise && pendSleep && ev.atOpEnd) pwrState <= PWR_DEEP;
        PWR_DEEP:
          if (ev.csRise && pendRel) begin
            pwrState <= PWR_WAKE;
            wakeCnt  <= WAKE_W'(WAKE_CYC - 1);
          end
        PWR_WAKE:
          if (wakeCnt == '0) pwrState <= PWR_STANDBY;
          else               wakeCnt  <= wakeCnt - 1'b1;
        default: pwrState <= PWR_STANDBY;
      endcase
    end
  end

  assign standby = (pwrState == PWR_STANDBY);
  assign deepPd  = (pwrState == PWR_DEEP);
endmodule

// File: rtl/spi_pd_responder.sv
module spi_pd_responder
  import spi_pd_pkg::*;
#(
  parameter int SIG_W       = 8,
  parameter logic [SIG_W-1:0] SIG_VAL = 8'h12,
  parameter int DUMMY_BYTES = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYC    = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  input  logic busy,
  output logic soData,
  output logic soOe,
  output logic standby,
  output logic deepPd,
  output logic wakeErr
);
  ctrl_strobe_t strobe;
  dp_event_t    ev;
  logic         csHighS;

  spi_pd_datapath #(
    .SIG_W(SIG_W), .SIG_VAL(SIG_VAL),
    .DUMMY_BYTES(DUMMY_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .siIn(siIn),
    .strobe(strobe), .ev(ev), .soData(soData), .soOe(soOe), .csHigh(csHighS)
  );

  spi_pd_ctrl #(.WAKE_CYC(WAKE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .busy(busy), .ev(ev), .strobe(strobe),
    .standby(standby), .deepPd(deepPd), .wakeErr(wakeErr)
  );
endmodule

// File: rtl/spi_pd_chk.sv
module spi_pd_chk #(
  parameter int SIG_W = 8,
  parameter logic [SIG_W-1:0] SIG_VAL = 8'h12
) (
  input logic clk,
  input logic rstN,
  input logic standby,
  input logic deepPd,
  input logic wakeErr,
  input logic soOe,
  input logic soData,
  input logic csHigh
);
  // R2
  sleep_from_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deepPd) |-> $past(standby));

  // R8
  standby_after_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |-> !$past(deepPd));

  // R8
  deep_exit_to_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deepPd) |-> !standby);

  // R9
  err_only_waking_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeErr |-> (!standby && !deepPd));

  // R4
  sig_msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> (soData == SIG_VAL[SIG_W-1]));

  // R10
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> !$past(csHigh));
endmodule

bind spi_pd_responder spi_pd_chk #(.SIG_W(SIG_W), .SIG_VAL(SIG_VAL)) chk_i (
  .clk(clk), .rstN(rstN), .standby(standby), .deepPd(deepPd),
  .wakeErr(wakeErr), .soOe(soOe), .soData(soData), .csHigh(csHighS)
);

// File: tb/spi_pd_responder_tb_top.sv
module spi_pd_responder_tb_top;
  localparam int HALF = 8;
  localparam int WAKE = 200;
  localparam logic [7:0] SIG = 8'h12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csNIn = 1'b1, siIn = 1'b0, busy = 1'b0;
  logic soData, soOe, standby, deepPd, wakeErr;

  always #10 clk = ~clk;

  spi_pd_responder #(.WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .siIn(siIn),
    .busy(busy), .soData(soData), .soOe(soOe), .standby(standby),
    .deepPd(deepPd), .wakeErr(wakeErr)
  );

  int total = 0, bad = 0, errPulses = 0;
  int modelPd = 0;
  bit done = 0;

  always @(negedge clk) if (wakeErr) errPulses++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiTx(input logic [63:0] mosi, input int nBits,
                       output logic [63:0] miso, output logic [63:0] oes);
    miso = '0; oes = '0;
    csNIn = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      siIn = mosi[63-i];
      waitClk(HALF);
      miso[63-i] = soData;
      oes[63-i]  = soOe;
      sckIn = 1'b1;
      waitClk(HALF);
      sckIn = 1'b0;
    end
    waitClk(HALF);
    csNIn = 1'b1;
    waitClk(HALF);
  endtask

  function automatic logic [63:0] sigMask(input int nBits);
    logic [63:0] m = '0;
    for (int i = 32; i < nBits; i++) m[63-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] sigBits(input int nBits);
    logic [63:0] r = '0;
    for (int i = 32; i < nBits; i++) r[63-i] = SIG[7-((i-32)%8)];
    return r;
  endfunction

  // one transaction with model-based expectations
  task automatic runTx(input logic [7:0] op, input int nBits, input bit busyV,
                       input string tag);
    logic [63:0] mosi, miso, oes, m;
    bit sigOn;
    mosi = {op, 24'($urandom), 32'($urandom)};
    busy = busyV;
    spiTx(mosi, nBits, miso, oes);
    busy = 1'b0;
    sigOn = (op == 8'hAB) && !busyV && nBits > 32;
    m = sigOn ? sigMask(nBits) : '0;
    chk(oes == m, tag, "oe pattern", oes, m);
    if (sigOn) chk((miso & m) == sigBits(nBits), tag, "signature bits",
                   miso & m, sigBits(nBits));
    chk(soOe == 1'b0, "R10", "oe after deselect", 64'(soOe), 64'd0);
    if (modelPd == 0) begin
      if (op == 8'hB9 && !busyV && nBits == 8) modelPd = 1;
    end else if (op == 8'hAB && !busyV && nBits >= 8) begin
      chk(!standby && !deepPd, "R8", "waking state", {62'd0, standby, deepPd}, 64'd0);
      waitClk(WAKE);
      modelPd = 0;
    end
    chk(standby == (modelPd == 0) && deepPd == (modelPd == 1), tag, "power state",
        {62'd0, standby, deepPd}, (modelPd == 1) ? 64'd1 : 64'd2);
  endtask

  initial begin
    logic [63:0] miso, oes;
    void'($urandom(32'd4242));
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    chk(standby && !deepPd && !soOe && !wakeErr, "R1", "reset outputs",
        {60'd0, standby, deepPd, soOe, wakeErr}, 64'h8);

    runTx(8'hAB, 48, 1'b0, "R7");   // R7 R4 R5: signature from standby, no delay
    runTx(8'hB9, 16, 1'b0, "R2");   // R2: overrun opcode refused
    runTx(8'hB9, 3,  1'b0, "R11");  // R11: cut short
    runTx(8'hAB, 5,  1'b0, "R11");
    runTx(8'hB9, 8,  1'b1, "R6");   // R6: busy blocks entry
    runTx(8'hB9, 8,  1'b0, "R2");   // R2: exact boundary enters
    runTx(8'h9F, 40, 1'b0, "R3");   // R3: other opcodes ignored
    runTx(8'hB9, 8,  1'b0, "R3");
    runTx(8'hAB, 40, 1'b1, "R6");   // R6: busy blocks release
    runTx(8'hAB, 64, 1'b0, "R5");   // R5 R8: repeat signature, wake

    // R9: select pulse during wake
    runTx(8'hB9, 8, 1'b0, "R2");
    errPulses = 0;
    spiTx({8'hAB, 56'd0}, 8, miso, oes);
    waitClk(20);
    csNIn = 1'b0; waitClk(10); csNIn = 1'b1; waitClk(10);
    chk(errPulses == 1, "R9", "error pulses", 64'(errPulses), 64'd1);
    chk(!standby && !deepPd, "R9", "still waking", {62'd0, standby, deepPd}, 64'd0);
    waitClk(WAKE);
    chk(standby && !deepPd, "R9", "wake completes", {62'd0, standby, deepPd}, 64'd2);
    modelPd = 0;

    // constrained random mix
    for (int t = 0; t < 40; t++) begin
      int lens[6] = '{3, 8, 8, 16, 36, 48};
      logic [7:0] ops[4] = '{8'hAB, 8'hB9, 8'hB9, 8'h05};
      logic [7:0] op = ops[$urandom_range(3)];
      if ($urandom_range(7) == 0) op = 8'($urandom);
      runTx(op, lens[$urandom_range(5)], ($urandom_range(3) == 0), "R4");
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule